// File: doc/BRIEF.md
# Register Bank Exception Sequencer

This block keeps count of how many interrupt register-save banks are in use. It watches two kinds of request: an interrupt accept that wants a bank, and an instruction that restores a bank. It raises an error when an accept arrives with every bank already full, or when a restore is asked for while no bank holds a saved context. Each error makes the block run the exception entry by itself. It reads the handler address from the vector table, pushes the status register and then a return address onto the stack, and hands the handler address, the new stack pointer and the new status register to the CPU as one jump. The jump has no delay slot.

The two error kinds behave differently. An overflow returns to the instruction after the last one executed. It also lifts the interrupt mask to the priority of the interrupt that caused it, so that the same interrupt cannot nest. An underflow returns to the restore instruction itself and leaves the status register as it was. The memory port is minimal: a read returns its data in the cycle after the request, and a write completes in the cycle it is issued.

Top module: `bank_exc_seq`

## Requirements
- R1: After reset the bank count is 0. A banked interrupt accept raises the count by one while it is below 15 (NUM_BANKS), and the count never leaves the range 0 to 15.
- R2: A restore request decrements the count while it is above 0. A restore request in the same cycle as any interrupt accept is dropped.
- R3: Overflow starts only when three things hold at once: the count is 15, the overflow enable is 1, and a banked interrupt is accepted. With the enable at 0 the accept gives no error and the count stays at 15. An accept without a bank leaves the count unchanged.
- R4: A restore request with the count at 0 starts an underflow, and the count stays at 0.
- R5: The first cycle of the sequence is a vector-table read at vector base + 4 × number. The number is 9 for overflow and 10 for underflow. The read data arrives in the next cycle.
- R6: The two cycles after the read are 32-bit stack writes. The first writes the status register, as it was at detection, to SP−4. The second writes the return address to SP−8.
- R7: The return address pushed is the next-instruction PC for an overflow and the current PC for an underflow, both taken at detection.
- R8: On overflow, bits 7:4 (the interrupt mask) of the new status register hold the offending interrupt's priority level, and every other bit is kept. On underflow the new status register equals the saved one.
- R9: In the fourth cycle after detection, jump_valid is high for exactly one cycle. In that cycle jump_pc is the fetched vector and new_sp is SP−8. In the following cycle the block is idle.
- R10: busy is high from the cycle after detection through the jump cycle. Accepts and restore requests seen while busy change nothing.
- R11: Reset is synchronous and active low. It leaves busy, mem_req and jump_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_take | input | 1 | Interrupt accept strobe |
| irq_banked | input | 1 | Accepted interrupt uses a register bank |
| irq_level | input | 4 | Priority level of the accepted interrupt |
| resbank_req | input | 1 | Restore-bank instruction strobe |
| ovf_en | input | 1 | Overflow error acceptance enable |
| cur_pc | input | 32 | Address of the executing instruction |
| next_pc | input | 32 | Address of the instruction after the last executed one |
| sr_in | input | 32 | Current status register |
| sp_in | input | 32 | Current stack pointer |
| vbr_in | input | 32 | Vector table base address |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| busy | output | 1 | Exception sequence in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| jump_valid | output | 1 | One-cycle jump strobe |
| jump_pc | output | 32 | Handler start address |
| new_sp | output | 32 | Stack pointer after the pushes |
| new_sr | output | 32 | Status register for the handler |
| bank_count | output | 4 | Number of banks holding a saved context |

## Verification
A stimulus driven between edges is detected at the next rising edge. The count changes at that same edge. The vector read is visible one cycle later, the status push two cycles later, the return push three cycles later and the jump four cycles later, and the block is idle again after five. The bench model steps through those same phases edge by edge. It compares every output on the falling edge that follows, so each value is checked in the exact cycle it is due, and any early or late change shows up as a mismatch in that cycle. Accepts and restores are also issued while the block is busy, and the count, the access sequence and the jump must stay as if those requests had never been sent.

// File: rtl/bank_exc_pkg.sv
// Shared types for the register bank exception sequencer.
// Assumes a 32-bit address and data path.
package bank_exc_pkg;
    localparam int XLEN = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VEC_RD,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_JUMP
    } seq_state_t;

    typedef enum logic {
        ERR_OVF = 1'b0,
        ERR_UNF = 1'b1
    } err_kind_t;

    typedef struct packed {
        err_kind_t         kind;
        logic [XLEN-1:0]   ret_pc;
        logic [XLEN-1:0]   sr;
        logic [XLEN-1:0]   sp;
        logic [XLEN-1:0]   vbr;
        logic [3:0]        lvl;
    } err_ctx_t;
endpackage

// File: rtl/bank_tracker.sv
// Bank occupancy counter with overflow/underflow detection.
// Assumes: requests are single-cycle strobes; while busy is high every
// request is ignored; an interrupt accept wins over a same-cycle restore.
module bank_tracker #(
    parameter int NUM_BANKS = 15,
    localparam int CW = $clog2(NUM_BANKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          irq_take,
    input  logic          irq_banked,
    input  logic          resbank_req,
    input  logic          ovf_en,
    output logic [CW-1:0] cnt,
    output logic          ovf_hit,
    output logic          unf_hit
);
    logic full;
    logic empty;
    logic take_bank;
    logic do_restore;

    // Qualify requests and flag error conditions.
    always_comb begin
        full       = (cnt == CW'(NUM_BANKS));
        empty      = (cnt == '0);
        take_bank  = !busy && irq_take && irq_banked;
        do_restore = !busy && !irq_take && resbank_req;
        ovf_hit    = take_bank && full && ovf_en;
        unf_hit    = do_restore && empty;
    end

    // Occupancy count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (take_bank && !full) begin
            cnt <= cnt + CW'(1);
        end else if (do_restore && !empty) begin
            cnt <= cnt - CW'(1);
        end
    end

    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(NUM_BANKS));

    a_r3_full_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (full && irq_take && irq_banked && !busy) |=> (cnt == CW'(NUM_BANKS)));

    a_r4_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && resbank_req && !irq_take && !busy) |=> (cnt == '0));

    a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cnt));
endmodule

// File: rtl/exc_sequencer.sv
// Exception entry sequencer: vector read, SR push, PC push, jump.
// Assumes memory read data is valid the cycle after a read request and
// writes complete in the cycle they are issued. Context is captured at
// the detection edge, so inputs may change during the sequence.
module exc_sequencer
    import bank_exc_pkg::*;
#(
    parameter int VEC_OVF = 9,
    parameter int VEC_UNF = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ovf_hit,
    input  logic            unf_hit,
    input  logic [3:0]      irq_level,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] next_pc,
    input  logic [XLEN-1:0] sr_in,
    input  logic [XLEN-1:0] sp_in,
    input  logic [XLEN-1:0] vbr_in,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            jump_valid,
    output logic [XLEN-1:0] jump_pc,
    output logic [XLEN-1:0] new_sp,
    output logic [XLEN-1:0] new_sr
);
    localparam logic [XLEN-1:0] OFS_OVF = XLEN'(VEC_OVF * 4);
    localparam logic [XLEN-1:0] OFS_UNF = XLEN'(VEC_UNF * 4);

    seq_state_t      state;
    err_ctx_t        ctx;
    logic [XLEN-1:0] vec_q;

    // Status register seen by the handler: mask raised on overflow only.
    function automatic logic [XLEN-1:0] handler_sr(input err_ctx_t c);
        logic [XLEN-1:0] s;
        s = c.sr;
        if (c.kind == ERR_OVF) s[7:4] = c.lvl;
        return s;
    endfunction

    // Sequence state and captured context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ctx   <= '0;
            vec_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (ovf_hit || unf_hit) begin
                        state      <= ST_VEC_RD;
                        ctx.kind   <= ovf_hit ? ERR_OVF : ERR_UNF;
                        ctx.ret_pc <= ovf_hit ? next_pc : cur_pc;
                        ctx.sr     <= sr_in;
                        ctx.sp     <= sp_in;
                        ctx.vbr    <= vbr_in;
                        ctx.lvl    <= irq_level;
                    end
                end
                ST_VEC_RD:  state <= ST_PUSH_SR;
                ST_PUSH_SR: begin
                    vec_q <= mem_rdata;
                    state <= ST_PUSH_PC;
                end
                ST_PUSH_PC: state <= ST_JUMP;
                ST_JUMP:    state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Memory port and jump outputs decoded from the state.
    always_comb begin
        busy       = (state != ST_IDLE);
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        jump_valid = 1'b0;
        jump_pc    = '0;
        new_sp     = '0;
        new_sr     = '0;
        unique case (state)
            ST_VEC_RD: begin
                mem_req  = 1'b1;
                mem_addr = ctx.vbr + ((ctx.kind == ERR_OVF) ? OFS_OVF : OFS_UNF);
            end
            ST_PUSH_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctx.sp - XLEN'(4);
                mem_wdata = ctx.sr;
            end
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctx.sp - XLEN'(8);
                mem_wdata = ctx.ret_pc;
            end
            ST_JUMP: begin
                jump_valid = 1'b1;
                jump_pc    = vec_q;
                new_sp     = ctx.sp - XLEN'(8);
                new_sr     = handler_sr(ctx);
            end
            default: ;
        endcase
    end

    a_r5_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && !mem_we));

    a_r6_sr_then_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr == ctx.sp - XLEN'(4))
            |=> (mem_req && mem_we && mem_addr == ctx.sp - XLEN'(8)));

    a_r9_single_jump: assert property (@(posedge clk) disable iff (!rst_n)
        jump_valid |=> (!busy && !jump_valid));

    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !jump_valid) |=> busy);
endmodule

// File: rtl/bank_exc_seq.sv
// Top: register bank occupancy tracking plus exception entry sequencing.
// Assumes the interrupt controller and pipeline hold off their own work
// while busy is high; requests presented then are discarded.
module bank_exc_seq
    import bank_exc_pkg::*;
#(
    parameter int NUM_BANKS = 15,
    parameter int VEC_OVF   = 9,
    parameter int VEC_UNF   = 10,
    localparam int CW = $clog2(NUM_BANKS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_take,
    input  logic            irq_banked,
    input  logic [3:0]      irq_level,
    input  logic            resbank_req,
    input  logic            ovf_en,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] next_pc,
    input  logic [XLEN-1:0] sr_in,
    input  logic [XLEN-1:0] sp_in,
    input  logic [XLEN-1:0] vbr_in,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            jump_valid,
    output logic [XLEN-1:0] jump_pc,
    output logic [XLEN-1:0] new_sp,
    output logic [XLEN-1:0] new_sr,
    output logic [CW-1:0]   bank_count
);
    logic ovf_hit;
    logic unf_hit;

    bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy),
        .irq_take    (irq_take),
        .irq_banked  (irq_banked),
        .resbank_req (resbank_req),
        .ovf_en      (ovf_en),
        .cnt         (bank_count),
        .ovf_hit     (ovf_hit),
        .unf_hit     (unf_hit)
    );

    exc_sequencer #(.VEC_OVF(VEC_OVF), .VEC_UNF(VEC_UNF)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_hit    (ovf_hit),
        .unf_hit    (unf_hit),
        .irq_level  (irq_level),
        .cur_pc     (cur_pc),
        .next_pc    (next_pc),
        .sr_in      (sr_in),
        .sp_in      (sp_in),
        .vbr_in     (vbr_in),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .jump_valid (jump_valid),
        .jump_pc    (jump_pc),
        .new_sp     (new_sp),
        .new_sr     (new_sr)
    );
endmodule

// File: tb/test_bank_exc_seq.sv
module test_bank_exc_seq;
    localparam logic [31:0] VBR  = 32'h0000_1000;
    localparam logic [31:0] HOVF = 32'h0000_4A00;
    localparam logic [31:0] HUNF = 32'h0000_5B00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_take = 1'b0, irq_banked = 1'b0, resbank_req = 1'b0, ovf_en = 1'b0;
    logic [3:0]  irq_level = 4'd0;
    logic [31:0] cur_pc = '0, next_pc = '0, sr_in = '0, sp_in = '0, vbr_in = VBR;
    logic [31:0] mem_rdata = '0;
    logic busy, mem_req, mem_we, jump_valid;
    logic [31:0] mem_addr, mem_wdata, jump_pc, new_sp, new_sr;
    logic [3:0]  bank_count;

    bank_exc_seq i_bank_exc_seq (.*);

    always #5 clk = ~clk;

    // Memory: vector table and stack.
    logic [31:0] mem [logic [31:0]];
    initial begin
        mem[VBR + 32'd36] = HOVF;
        mem[VBR + 32'd40] = HUNF;
    end
    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        if (mem_req && mem_we) mem[mem_addr] = mem_wdata;
    end

    // Behavioural reference model.
    int m_cnt = 0, m_ph = 0;
    bit m_ovf;
    logic [31:0] m_ret, m_sr, m_sp;
    logic [3:0] m_lvl;

    task automatic start_err(input bit ovf);
        m_ph  = 1;
        m_ovf = ovf;
        m_ret = ovf ? next_pc : cur_pc;
        m_sr  = sr_in;
        m_sp  = sp_in;
        m_lvl = irq_level;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ph = 0;
        end else if (m_ph != 0) begin
            m_ph = (m_ph == 4) ? 0 : m_ph + 1;
        end else if (irq_take) begin
            if (irq_banked) begin
                if (m_cnt < 15) m_cnt++;
                else if (ovf_en) start_err(1'b1);
            end
        end else if (resbank_req) begin
            if (m_cnt > 0) m_cnt--;
            else start_err(1'b0);
        end
    end

    int errors = 0, checks = 0;
    bit chk_en = 1'b0, done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [31:0] esr;
        if (!chk_en) return;
        chk("R1 count", {28'b0, bank_count}, 32'(m_cnt));
        chk("R10 busy", {31'b0, busy}, {31'b0, m_ph != 0});
        chk("R5 req", {31'b0, mem_req}, {31'b0, m_ph >= 1 && m_ph <= 3});
        chk("R9 jump", {31'b0, jump_valid}, {31'b0, m_ph == 4});
        case (m_ph)
            1: begin
                chk("R5 read", {31'b0, mem_we}, 32'd0);
                chk("R5 vaddr", mem_addr, VBR + (m_ovf ? 32'd36 : 32'd40));
            end
            2: begin
                chk("R6 we", {31'b0, mem_we}, 32'd1);
                chk("R6 sr addr", mem_addr, m_sp - 32'd4);
                chk("R6 sr data", mem_wdata, m_sr);
            end
            3: begin
                chk("R6 pc addr", mem_addr, m_sp - 32'd8);
                chk("R7 ret pc", mem_wdata, m_ret);
            end
            4: begin
                esr = m_sr;
                if (m_ovf) esr[7:4] = m_lvl;
                chk("R9 target", jump_pc, m_ovf ? HOVF : HUNF);
                chk("R9 sp", new_sp, m_sp - 32'd8);
                chk("R8 sr", new_sr, esr);
            end
            default: ;
        endcase
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
        irq_take = 1'b0; irq_banked = 1'b0; resbank_req = 1'b0;
    endtask

    task automatic ctx(input int k);
        cur_pc  = 32'h0000_8000 + 32'(k * 16);
        next_pc = 32'h0000_8000 + 32'(k * 16) + 32'd2;
        sr_in   = 32'h4000_00F0 ^ 32'(k * 32'h0101_0003);
        sp_in   = 32'h0002_0000 - 32'(k * 64);
    endtask

    task automatic accept(input bit banked, input logic [3:0] lvl);
        irq_take = 1'b1; irq_banked = banked; irq_level = lvl;
        tick();
    endtask

    task automatic restore();
        resbank_req = 1'b1;
        tick();
    endtask

    initial begin
        repeat (2) tick();
        chk_en = 1'b1;
        tick();
        rst_n = 1'b1;
        // R11: reset state
        chk("R11 busy", {31'b0, busy}, 32'd0);
        chk("R11 req", {31'b0, mem_req}, 32'd0);
        chk("R11 count", {28'b0, bank_count}, 32'd0);

        // R4: underflow from empty, with requests while busy (R10)
        ctx(1);
        restore();
        accept(1'b1, 4'd3);
        restore();
        repeat (4) tick();
        chk("R4 count after underflow", {28'b0, bank_count}, 32'd0);

        // R1: fill, with non-banked accepts in between (R3)
        for (int i = 0; i < 15; i++) begin
            accept(1'b1, 4'(i));
            if (i == 7) accept(1'b0, 4'd2);
        end
        tick();
        chk("R1 full", {28'b0, bank_count}, 32'd15);

        // R3: overflow disabled, full -> no error
        ovf_en = 1'b0;
        ctx(2);
        accept(1'b1, 4'd6);
        tick();
        chk("R3 no error busy", {31'b0, busy}, 32'd0);

        // R2: restore together with accept is dropped
        irq_take = 1'b1; resbank_req = 1'b1;
        tick();
        tick();
        chk("R2 restore dropped", {28'b0, bank_count}, 32'd15);

        // R3/R7/R8: overflow enabled
        ovf_en = 1'b1;
        ctx(3);
        accept(1'b1, 4'd11);
        restore();
        accept(1'b1, 4'd1);
        repeat (4) tick();
        chk("R3 count after overflow", {28'b0, bank_count}, 32'd15);

        // R2: decrements
        repeat (3) restore();
        tick();
        chk("R2 decrement", {28'b0, bank_count}, 32'd12);

        // Second overflow with other context
        repeat (3) accept(1'b1, 4'd0);
        ctx(5);
        accept(1'b1, 4'd15);
        repeat (6) tick();

        // Drain and underflow again with other context
        ovf_en = 1'b0;
        for (int i = 0; i < 15; i++) restore();
        ctx(7);
        restore();
        repeat (6) tick();
        chk("R4 stack sr", mem[32'h0002_0000 - 32'd448 - 32'd4], 32'h4000_00F0 ^ 32'(7 * 32'h0101_0003));
        chk("R7 stack pc", mem[32'h0002_0000 - 32'd448 - 32'd8], 32'h0000_8000 + 32'd112);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule